// File: doc/BRIEF.md
# Pseudo-static RAM refresh arbiter

This block models, at clock level, the hidden refresh logic of a memory built from DRAM cells that shows an SRAM-style interface to its host. It holds a refresh interval timer, a 9-bit internal row counter and a row multiplexer that picks either an external row taken from the address pins or the internal counter value. All pulse widths and delays are counted in cycles of the system clock, and parameters convert the analog thresholds into cycle counts.

Three kinds of refresh request meet in one arbiter. A chip-enable cycle refreshes the row given by the low address bits. A short low pulse on the refresh pin, with the chip deselected, refreshes the row held by the internal counter. A long low level on the same pin enters self-refresh, in which the interval timer issues counter rows on its own until the pin returns high. Every granted refresh produces a one-cycle row-activate strobe, the row address, and a busy flag that the surrounding logic uses to float the data pins.

Top module: `psram_refresh_arb`

## Requirements
- R1: The chip is selected only while `ce1_n` is 0 and `ce2` is 1; each cycle in which selection begins (with `rfsh_n` high) is a chip-enable refresh request whose row is `addr[8:0]`; `addr[16:9]` has no effect on the row; `row_o` changes only in the cycle `act_o` is 1.
- R2: The internal row counter is 9 bits, is 0 after reset, supplies the row of every auto and self refresh, advances by one after each of them and wraps from 511 to 0.
- R3: A low level on `rfsh_n` lasting from MIN_PULSE to SELF_THRESH-1 cycles, with the chip deselected, yields exactly one refresh of the internal row after `rfsh_n` returns high.
- R4: A low level shorter than MIN_PULSE, a low level that follows a high level shorter than MIN_PULSE, or a low level during which the chip becomes selected, yields no refresh.
- R5: When `rfsh_n` has been low for SELF_THRESH cycles with the chip deselected, `self_o` rises and one internal refresh is requested; a further one is requested every SELF_PERIOD cycles while `rfsh_n` stays low; the return to high clears `self_o` and requests nothing.
- R6: Selection that begins while `rfsh_n` is low, or within RECOV_CYC cycles after `rfsh_n` returns high from self-refresh, is ignored; selection that begins after that delay is served.
- R7: Each grant drives `act_o` for exactly one cycle; `busy_o` is 1 for the BUSY_CYC cycles starting with that cycle, and two grants are at least BUSY_CYC+1 cycles apart.
- R8: `busy_o` stays 1 for the whole time `self_o` is 1, so the data pins stay floated during self-refresh.
- R9: Requests arriving while a refresh is in progress are held and served later, up to PEND_MAX internal ones; when a chip-enable request and an internal request both wait, the chip-enable request is served first.
- R10: After reset `act_o`, `busy_o` and `self_o` are 0 and `row_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| rfsh_n | input | 1 | Refresh request pin, active low |
| addr | input | ADDR_W | Address pins; low ROW_W bits give the row of a chip-enable refresh |
| act_o | output | 1 | One-cycle row-activate strobe |
| row_o | output | ROW_W | Row being refreshed, held until the next strobe |
| busy_o | output | 1 | Refresh in progress or self-refresh active; data pins float |
| self_o | output | 1 | Self-refresh mode active |

## Verification
The checker watches, on every cycle, that the strobe lasts one cycle, that it always coincides with busy, that strobes never come closer than the busy window allows, that the row output only moves with a strobe, that the internal counter only steps by one and only on a strobe, and that self-refresh is entered and left only with the matching pin level. Which row is chosen, the pulse-width thresholds, the rejection of badly timed or selected pulses, the recovery window after self-refresh, the order in which waiting requests are served and the wrap of the counter after 512 rows can only be shown by the bench's scenarios, which compare the logged strobes with rows worked out from the stimulus.

// File: rtl/psram_refresh_arb.sv
module psram_refresh_arb #(
  parameter int ADDR_W      = 17,
  parameter int ROW_W       = 9,
  parameter int MIN_PULSE   = 3,
  parameter int SELF_THRESH = 800,
  parameter int SELF_PERIOD = 1500,
  parameter int BUSY_CYC    = 6,
  parameter int RECOV_CYC   = 16,
  parameter int PEND_MAX    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              rfsh_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              act_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              busy_o,
  output logic              self_o
);
  localparam int LO_W = $clog2(SELF_THRESH + 1);
  localparam int HI_W = $clog2(MIN_PULSE + 1);
  localparam int TM_W = $clog2(SELF_PERIOD);
  localparam int BC_W = $clog2(BUSY_CYC + 1);
  localparam int RC_W = $clog2(RECOV_CYC + 1);
  localparam int PD_W = $clog2(PEND_MAX + 1);

  localparam logic [LO_W-1:0] LO_SAT  = LO_W'(SELF_THRESH);
  localparam logic [LO_W-1:0] LO_MIN  = LO_W'(MIN_PULSE);
  localparam logic [HI_W-1:0] HI_MIN  = HI_W'(MIN_PULSE);
  localparam logic [TM_W-1:0] TM_LAST = TM_W'(SELF_PERIOD - 1);
  localparam logic [BC_W-1:0] BC_LD   = BC_W'(BUSY_CYC);
  localparam logic [RC_W-1:0] RC_LD   = RC_W'(RECOV_CYC);
  localparam logic [PD_W-1:0] PD_MAX  = PD_W'(PEND_MAX);

  logic             sel_q, rfsh_q, self_q, pulse_ok, pce, act_q;
  logic [LO_W-1:0]  lo_cnt, lo_nxt;
  logic [HI_W-1:0]  hi_cnt;
  logic [TM_W-1:0]  stmr;
  logic [BC_W-1:0]  bcnt;
  logic [RC_W-1:0]  rcv;
  logic [PD_W-1:0]  pint;
  logic [ROW_W-1:0] pce_row, rcnt, row_q;
  logic             unused_hi;

  wire sel  = ~ce1_n & ce2;
  wire fall = ~rfsh_n & rfsh_q;
  wire rise = rfsh_n & ~rfsh_q;

  assign lo_nxt = fall ? LO_W'(1) : ((lo_cnt == LO_SAT) ? lo_cnt : lo_cnt + 1'b1);

  wire ok_now   = fall ? (~sel & (hi_cnt >= HI_MIN)) : (pulse_ok & ~sel);
  wire self_go  = ~rfsh_n & ~self_q & ok_now & (lo_nxt == LO_SAT);
  wire tick_sf  = ~rfsh_n & self_q & (stmr == TM_LAST);
  wire auto_go  = rise & ~self_q & pulse_ok & (lo_cnt >= LO_MIN);
  wire int_req  = self_go | tick_sf | auto_go;
  wire ce_go    = sel & ~sel_q & rfsh_n & (rcv == '0);
  wire idle     = (bcnt == '0);
  wire gnt_ce   = idle & pce;
  wire gnt_int  = idle & ~pce & (pint != '0);

  assign unused_hi = ^addr[ADDR_W-1:ROW_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      rfsh_q   <= 1'b1;
      lo_cnt   <= '0;
      hi_cnt   <= HI_MIN;
      pulse_ok <= 1'b0;
    end else begin
      sel_q  <= sel;
      rfsh_q <= rfsh_n;
      if (!rfsh_n) begin
        lo_cnt   <= lo_nxt;
        pulse_ok <= ok_now;
      end else if (rise) begin
        hi_cnt <= HI_W'(1);
      end else if (hi_cnt != HI_MIN) begin
        hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      self_q <= 1'b0;
      stmr   <= '0;
      rcv    <= '0;
    end else begin
      if (self_go)     self_q <= 1'b1;
      else if (rfsh_n) self_q <= 1'b0;
      if (!self_q || self_go || tick_sf) stmr <= '0;
      else                                stmr <= stmr + 1'b1;
      if (rise && self_q)  rcv <= RC_LD;
      else if (rcv != '0)  rcv <= rcv - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pint    <= '0;
      pce     <= 1'b0;
      pce_row <= '0;
      act_q   <= 1'b0;
      row_q   <= '0;
      rcnt    <= '0;
      bcnt    <= '0;
    end else begin
      if (int_req && !gnt_int && pint != PD_MAX) pint <= pint + 1'b1;
      else if (!int_req && gnt_int)              pint <= pint - 1'b1;
      if (ce_go) begin
        pce     <= 1'b1;
        pce_row <= addr[ROW_W-1:0];
      end else if (gnt_ce) begin
        pce <= 1'b0;
      end
      act_q <= gnt_ce | gnt_int;
      if (gnt_ce) begin
        row_q <= pce_row;
      end else if (gnt_int) begin
        row_q <= rcnt;
        rcnt  <= rcnt + 1'b1;
      end
      if (gnt_ce || gnt_int) bcnt <= BC_LD;
      else if (!idle)        bcnt <= bcnt - 1'b1;
    end
  end

  assign act_o  = act_q;
  assign row_o  = row_q;
  assign busy_o = ~idle | self_q;
  assign self_o = self_q;
endmodule

// File: rtl/psram_refresh_arb_chk.sv
module psram_refresh_arb_chk #(
  parameter int ROW_W    = 9,
  parameter int BUSY_CYC = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rfsh_n,
  input logic             act_o,
  input logic             busy_o,
  input logic             self_o,
  input logic [ROW_W-1:0] row_o,
  input logic [ROW_W-1:0] rcnt
);
  localparam int GW = $clog2(BUSY_CYC + 2);
  localparam logic [GW-1:0] GSAT = GW'(BUSY_CYC + 1);

  logic [GW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap <= GSAT;
    else if (act_o)       gap <= GW'(1);
    else if (gap != GSAT) gap <= gap + 1'b1;
  end

  p_act_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) act_o |=> !act_o);
  p_act_busy_r7:  assert property (@(posedge clk) disable iff (!rst_n) act_o |-> busy_o);
  p_gap_r7:       assert property (@(posedge clk) disable iff (!rst_n) act_o |-> gap == GSAT);
  p_row_hold_r1:  assert property (@(posedge clk) disable iff (!rst_n) !act_o |-> $stable(row_o));
  p_cnt_step_r2:  assert property (@(posedge clk) disable iff (!rst_n)
                    (rcnt != $past(rcnt)) |-> (rcnt == $past(rcnt) + 1'b1));
  p_cnt_act_r2:   assert property (@(posedge clk) disable iff (!rst_n) (rcnt != $past(rcnt)) |-> act_o);
  p_self_in_r5:   assert property (@(posedge clk) disable iff (!rst_n) $rose(self_o) |-> !$past(rfsh_n));
  p_self_out_r5:  assert property (@(posedge clk) disable iff (!rst_n) $fell(self_o) |-> $past(rfsh_n));
endmodule

bind psram_refresh_arb psram_refresh_arb_chk #(.ROW_W(ROW_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rfsh_n(rfsh_n), .act_o(act_o), .busy_o(busy_o),
  .self_o(self_o), .row_o(row_o), .rcnt(rcnt)
);

// File: tb/tb_psram_refresh_arb.sv
`timescale 1ns/1ps
module tb_psram_refresh_arb;
  localparam int MINP = 3, THR = 20, PER = 10, BUSY = 8, REC = 12;

  logic clk = 0, rst_n = 0, ce1_n = 1, ce2 = 0, rfsh_n = 1;
  logic [16:0] addr = '0;
  logic act_o, busy_o, self_o;
  logic [8:0] row_o;

  psram_refresh_arb #(.MIN_PULSE(MINP), .SELF_THRESH(THR), .SELF_PERIOD(PER),
                      .BUSY_CYC(BUSY), .RECOV_CYC(REC)) dut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .rfsh_n(rfsh_n), .addr(addr),
    .act_o(act_o), .row_o(row_o), .busy_o(busy_o), .self_o(self_o));

  always #5 clk = ~clk;

  int total = 0, fails = 0;
  int n_act = 0, run = 0, last_run = 0;
  logic [8:0] logr [1024];
  bit seq_en = 0; int seq_exp = 0, seq_bad = 0;
  int exp_int = 0;

  always @(negedge clk) if (rst_n) begin
    if (act_o) begin
      logr[n_act % 1024] = row_o;
      n_act++;
      if (seq_en) begin
        if (int'(row_o) != seq_exp) seq_bad++;
        seq_exp = (seq_exp + 1) % 512;
      end
    end
    if (busy_o) run++;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin fails++; $display("FAIL %s: got %0d expected %0d", tag, got, exp); end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse(input int lo);
    rfsh_n = 0; tick(lo); rfsh_n = 1; tick(20);
  endtask

  localparam logic [25:0] VEC [8] = '{
    {17'h1FFFF, 9'h1FF}, {17'h00000, 9'h000}, {17'h1FE00, 9'h000}, {17'h001FF, 9'h1FF},
    {17'h0AA55, 9'h055}, {17'h15432, 9'h032}, {17'h00100, 9'h100}, {17'h1FF01, 9'h101}};

  initial begin
    int n0;
    tick(3); rst_n = 1; tick(2);
    chk(act_o == 0 && busy_o == 0 && self_o == 0 && row_o == 0, "R10 reset state",
        {act_o, busy_o, self_o}, 0);

    for (int i = 0; i < 8; i++) begin
      n0 = n_act;
      addr = VEC[i][25:9]; ce1_n = 0; ce2 = 1; tick(1);
      if (i % 2 == 0) ce1_n = 1; else ce2 = 0;
      addr = ~VEC[i][25:9]; tick(14);
      chk(n_act == n0 + 1 && logr[n0] == VEC[i][8:0], "R1 chip-enable row",
          int'(logr[n0]), int'(VEC[i][8:0]));
      if (i == 0) chk(last_run == BUSY, "R7 busy length", last_run, BUSY);
      ce1_n = 1; ce2 = 0;
    end

    n0 = n_act;
    ce1_n = 0; ce2 = 0; tick(2); ce1_n = 1; ce2 = 1; tick(2); ce2 = 0; tick(12);
    chk(n_act == n0, "R1 single enable does not select", n_act - n0, 0);

    n0 = n_act;
    pulse(MINP); pulse(10); pulse(THR - 1);
    chk(n_act == n0 + 3, "R3 auto pulses count", n_act - n0, 3);
    for (int k = 0; k < 3; k++)
      chk(logr[n0 + k] == 9'(exp_int + k), "R2 counter rows", int'(logr[n0 + k]), exp_int + k);
    exp_int += 3;

    n0 = n_act;
    pulse(MINP - 1);
    chk(n_act == n0, "R4 short pulse", n_act - n0, 0);
    rfsh_n = 0; tick(1); ce1_n = 0; ce2 = 1; tick(2); ce1_n = 1; ce2 = 0; tick(3);
    rfsh_n = 1; tick(20);
    chk(n_act == n0, "R4 R6 selected pulse", n_act - n0, 0);
    rfsh_n = 0; tick(5); rfsh_n = 1; tick(1); rfsh_n = 0; tick(5); rfsh_n = 1; tick(20);
    chk(n_act == n0 + 1 && logr[n0] == 9'(exp_int), "R4 short high time",
        n_act - n0, 1);
    exp_int += 1;

    n0 = n_act;
    rfsh_n = 0; tick(30);
    chk(self_o == 1, "R5 self entered", self_o, 1);
    chk(busy_o == 1, "R8 busy in self", busy_o, 1);
    tick(45);
    chk(n_act == n0 + 6, "R5 self refresh count", n_act - n0, 6);
    chk(logr[n0 + 5] == 9'(exp_int + 5), "R2 self rows", int'(logr[n0 + 5]), exp_int + 5);
    exp_int += 6;
    n0 = n_act;
    rfsh_n = 1; tick(1);
    ce1_n = 0; ce2 = 1; addr = 17'h00077; tick(2); ce1_n = 1; ce2 = 0; tick(6);
    chk(n_act == n0 && self_o == 0, "R6 recovery blocks select / R5 exit", n_act - n0, 0);
    tick(6);
    ce1_n = 0; ce2 = 1; addr = 17'h01234; tick(1); ce1_n = 1; ce2 = 0; tick(12);
    chk(n_act == n0 + 1 && logr[n0] == 9'h034, "R6 select after recovery",
        int'(logr[n0]), 'h034);

    n0 = n_act;
    ce1_n = 0; ce2 = 1; addr = 17'h00011; tick(1); ce1_n = 1; ce2 = 0;
    rfsh_n = 0; tick(3); rfsh_n = 1; tick(1);
    ce1_n = 0; ce2 = 1; addr = 17'h1FE22; tick(1); ce1_n = 1; ce2 = 0; tick(30);
    chk(n_act == n0 + 3, "R9 none lost", n_act - n0, 3);
    chk(logr[n0 + 1] == 9'h022, "R9 chip-enable first", int'(logr[n0 + 1]), 'h022);
    chk(logr[n0 + 2] == 9'(exp_int), "R9 internal after", int'(logr[n0 + 2]), exp_int);
    exp_int += 1;

    n0 = n_act;
    seq_exp = exp_int; seq_bad = 0; seq_en = 1;
    rfsh_n = 0; tick(THR + PER * 529 + 5); rfsh_n = 1;
    tick(20); seq_en = 0;
    chk(n_act == n0 + 530, "R5 long self count", n_act - n0, 530);
    chk(seq_bad == 0, "R2 consecutive rows with wrap", seq_bad, 0);
    exp_int = (exp_int + 530) % 512;
    n0 = n_act;
    pulse(5);
    chk(n_act == n0 + 1 && logr[n0] == 9'(exp_int), "R2 row after wrap",
        int'(logr[n0]), exp_int);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule